// File: doc/BRIEF.md
# Word-Granular Descending Stack Unit

This block keeps a last-in, first-out stack in a word-wide synchronous memory. It tracks the stack with a byte-addressed pointer. The pointer always holds the address of the most recently stored word. The stack grows toward lower addresses, two byte addresses per word. A push first moves the pointer down by two and then writes the word there. A pop first reads the word under the pointer and then moves the pointer up by two. Only full words are stored.

Two inputs define the legal window. The base address is the pointer value of an empty stack. The limit address is the lowest pointer value a stored word may occupy. A push that would take the pointer below the limit is refused, and so is a pop that would take it above the base. A refused request is consumed but changes nothing except a sticky error flag, which stays set until the clear input is pulsed.

Requests arrive on a valid/ready stream that carries an operation bit and a data word. Pop data leaves on a second valid/ready stream one cycle after the pop is taken. While that output holds an unconsumed word, the request side deasserts ready, so a stalled consumer back-pressures the requester. A separate load strobe writes the pointer directly. It takes priority over any request in the same cycle.

Top module: `wstk_top`

## Requirements
- R1: After reset the pointer equals parameter SP_RST (default 0), both error flags are low, the output stream is not valid and request ready is high.
- R2: An accepted push (req_pop = 0) that fits the window sets the pointer to its old value minus 2 and stores the word at the new pointer.
- R3: An accepted pop (req_pop = 1) that fits the window presents the word stored at the old pointer on the output stream in the cycle after acceptance, and the pointer becomes its old value plus 2.
- R4: Words leave in the reverse of the order they were stored: pushing A, B, C and then popping three times returns C, B, A.
- R5: A push when pointer − 2 < lim_addr (unsigned) is refused. The pointer and memory stay unchanged and ovf_err becomes 1.
- R6: A pop when pointer + 2 > base_addr (unsigned) is refused. The pointer stays unchanged, no output word is produced and unf_err becomes 1.
- R7: ovf_err and unf_err stay high until err_clr is pulsed. A new error in the same cycle as err_clr wins.
- R8: When sp_load is high, the pointer takes sp_load_val on the next edge, req_ready is low and no request is accepted.
- R9: While out_valid is high and out_ready is low, out_data holds steady, out_valid stays high and req_ready is low.
- R10: Bit 0 of the pointer is ignored when the memory is indexed: word index = pointer[AW-1:1].
- R11: stk_full is high exactly when a push would be refused, and stk_empty is high exactly when a pop would be refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_addr | input | AW | Lowest pointer value a stored word may occupy |
| base_addr | input | AW | Pointer value of an empty stack |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_pop | input | 1 | 1 = pop, 0 = push |
| req_data | input | DW | Word to push |
| out_valid | output | 1 | Popped word present |
| out_ready | input | 1 | Consumer takes popped word |
| out_data | output | DW | Popped word |
| sp_load | input | 1 | Load pointer strobe |
| sp_load_val | input | AW | Value loaded into pointer |
| err_clr | input | 1 | Clears both error flags |
| sp_out | output | AW | Current pointer |
| ovf_err | output | 1 | Sticky overflow flag |
| unf_err | output | 1 | Sticky underflow flag |
| stk_full | output | 1 | A push would be refused |
| stk_empty | output | 1 | A pop would be refused |

## Verification
A vector walk stores three distinct words and pops two of them, then refills the stack to the limit. This separates LIFO order from FIFO order and from a read of a fixed slot. One more push at the limit and one more pop at the base tell apart a refused request and a wrap of the pointer. Directed patterns cover the rest. A stalled consumer shows that the popped word holds and requests are held off. A load that collides with a request shows that the load wins. An odd pointer shows that bit 0 drops out of the word index. Other directed patterns show that the error flags stay set and that the clear removes them.

// File: rtl/wstk_pkg.sv
package wstk_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_LOAD = 2'd3
  } wstk_op_e;
endpackage

// File: rtl/wstk_bound.sv
module wstk_bound #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] lim,
  input  logic [AW-1:0] base,
  output logic          push_ok,
  output logic          pop_ok
);
  localparam logic [AW:0] STEP = (AW+1)'(2);

  logic [AW:0] sp_x, lim_x, base_x;

  always_comb begin
    sp_x    = {1'b0, sp};
    lim_x   = {1'b0, lim};
    base_x  = {1'b0, base};
    // widened compare so neither bound can wrap
    push_ok = (sp_x >= lim_x + STEP);
    pop_ok  = (sp_x + STEP <= base_x);
  end
endmodule

// File: rtl/wstk_ram.sv
module wstk_ram #(
  parameter int DW = 16,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read register only moves on a read, so a stalled word is held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wstk_ptr.sv
module wstk_ptr #(
  parameter int          AW     = 8,
  parameter logic [AW-1:0] SP_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          dec,
  input  logic          inc,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_dn
);
  localparam logic [AW-1:0] WSTEP = AW'(2);

  assign sp_dn = sp - WSTEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp <= SP_RST;
    else if (ld)  sp <= ld_val;
    else if (dec) sp <= sp_dn;
    else if (inc) sp <= sp + WSTEP;
  end
endmodule

// File: rtl/wstk_top.sv
module wstk_top #(
  parameter int            AW     = 8,
  parameter int            DW     = 16,
  parameter logic [AW-1:0] SP_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lim_addr,
  input  logic [AW-1:0] base_addr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_pop,
  input  logic [DW-1:0] req_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic          sp_load,
  input  logic [AW-1:0] sp_load_val,
  input  logic          err_clr,
  output logic [AW-1:0] sp_out,
  output logic          ovf_err,
  output logic          unf_err,
  output logic          stk_full,
  output logic          stk_empty
);
  import wstk_pkg::*;

  localparam int IW = AW - 1;

  logic [AW-1:0] sp, sp_dn;
  logic          push_ok, pop_ok;
  logic          take;
  wstk_op_e      op;
  logic          do_push, do_pop, bad_push, bad_pop;
  logic          stalled;

  assign stalled   = out_valid && !out_ready;
  assign req_ready = !sp_load && !stalled;
  assign take      = req_valid && req_ready;

  always_comb begin
    if (sp_load)   op = OP_LOAD;
    else if (take) op = req_pop ? OP_POP : OP_PUSH;
    else           op = OP_IDLE;
  end

  assign do_push  = (op == OP_PUSH) &&  push_ok;
  assign bad_push = (op == OP_PUSH) && !push_ok;
  assign do_pop   = (op == OP_POP)  &&  pop_ok;
  assign bad_pop  = (op == OP_POP)  && !pop_ok;

  wstk_bound #(.AW(AW)) u_bound (
    .sp(sp), .lim(lim_addr), .base(base_addr),
    .push_ok(push_ok), .pop_ok(pop_ok)
  );

  wstk_ptr #(.AW(AW), .SP_RST(SP_RST)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .ld(op == OP_LOAD), .ld_val(sp_load_val),
    .dec(do_push), .inc(do_pop),
    .sp(sp), .sp_dn(sp_dn)
  );

  wstk_ram #(.DW(DW), .IW(IW)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(do_push), .waddr(sp_dn[AW-1:1]), .wdata(req_data),
    .re(do_pop), .raddr(sp[AW-1:1]), .rdata(out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ovf_err   <= 1'b0;
      unf_err   <= 1'b0;
    end else begin
      if (do_pop)         out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
      if (bad_push)       ovf_err <= 1'b1;
      else if (err_clr)   ovf_err <= 1'b0;
      if (bad_pop)        unf_err <= 1'b1;
      else if (err_clr)   unf_err <= 1'b0;
    end
  end

  assign sp_out    = sp;
  assign stk_full  = !push_ok;
  assign stk_empty = !pop_ok;
endmodule

// File: rtl/wstk_chk.sv
module wstk_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_pop,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          sp_load,
  input logic [AW-1:0] sp_load_val,
  input logic          err_clr,
  input logic [AW-1:0] sp_out,
  input logic          ovf_err,
  input logic          unf_err,
  input logic          stk_full,
  input logic          stk_empty
);
  logic acc_push, acc_pop;
  assign acc_push = req_valid && req_ready && !req_pop;
  assign acc_pop  = req_valid && req_ready &&  req_pop;

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    acc_push && !stk_full |=> sp_out == $past(sp_out) - AW'(2)); // R2
  AST_POP_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pop && !stk_empty |=> out_valid && sp_out == $past(sp_out) + AW'(2)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_push && stk_full |=> ovf_err && $stable(sp_out)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pop && stk_empty |=> unf_err && $stable(sp_out)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err && !err_clr |=> ovf_err); // R7
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err && !err_clr |=> unf_err); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |=> sp_out == $past(sp_load_val)); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !req_ready); // R9
endmodule

bind wstk_top wstk_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_pop(req_pop), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .sp_load(sp_load), .sp_load_val(sp_load_val),
  .err_clr(err_clr), .sp_out(sp_out), .ovf_err(ovf_err), .unf_err(unf_err),
  .stk_full(stk_full), .stk_empty(stk_empty)
);

// File: tb/sim_wstk_top.sv
`timescale 1ns/1ps
module sim_wstk_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NV = 15;
  // op: 0 push, 1 pop, 2 load
  localparam logic [1:0]    V_OP  [NV] = '{2,0,0,0,1,1,0,0,0,0,1,1,1,1,1};
  localparam logic [DW-1:0] V_DAT [NV] = '{16'h0020,16'hA111,16'hB222,16'hC333,16'hC333,
    16'hB222,16'hD444,16'hE555,16'hF666,16'h7777,16'hF666,16'hE555,16'hD444,16'hA111,16'h0000};
  localparam logic [AW-1:0] V_SP  [NV] = '{8'h20,8'h1E,8'h1C,8'h1A,8'h1C,8'h1E,8'h1C,8'h1A,
    8'h18,8'h18,8'h1A,8'h1C,8'h1E,8'h20,8'h20};
  localparam logic          V_RV  [NV] = '{0,0,0,0,1,1,0,0,0,0,1,1,1,1,0};
  localparam logic          V_OVF [NV] = '{0,0,0,0,0,0,0,0,0,1,1,1,1,1,1};
  localparam logic          V_UNF [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,1};

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] lim_addr = 8'h18, base_addr = 8'h20;
  logic req_valid = 0, req_pop = 0, out_ready = 1, sp_load = 0, err_clr = 0;
  logic [DW-1:0] req_data = '0;
  logic [AW-1:0] sp_load_val = '0;
  logic req_ready, out_valid, ovf_err, unf_err, stk_full, stk_empty;
  logic [DW-1:0] out_data;
  logic [AW-1:0] sp_out;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wstk_top #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .lim_addr(lim_addr), .base_addr(base_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_pop(req_pop),
    .req_data(req_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .sp_load(sp_load), .sp_load_val(sp_load_val),
    .err_clr(err_clr), .sp_out(sp_out), .ovf_err(ovf_err), .unf_err(unf_err),
    .stk_full(stk_full), .stk_empty(stk_empty)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, return at the next negedge
  task automatic step(input logic v, input logic pop, input logic [DW-1:0] d,
                      input logic ld, input logic [AW-1:0] lv);
    req_valid = v; req_pop = pop; req_data = d; sp_load = ld; sp_load_val = lv;
    @(negedge clk);
    req_valid = 0; sp_load = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sp reset", sp_out, 0);
    chk("R1 flags reset", {ovf_err, unf_err}, 0);
    chk("R1 out_valid reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);

    // vector walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      step(V_OP[i] != 2, V_OP[i] == 1, V_DAT[i], V_OP[i] == 2, V_DAT[i][AW-1:0]);
      chk($sformatf("R2/R3 sp vec%0d", i), sp_out, V_SP[i]);
      chk($sformatf("R3/R6 valid vec%0d", i), out_valid, V_RV[i]);
      if (V_RV[i]) chk($sformatf("R4 data vec%0d", i), out_data, V_DAT[i]);
      chk($sformatf("R5 ovf vec%0d", i), ovf_err, V_OVF[i]);
      chk($sformatf("R6 unf vec%0d", i), unf_err, V_UNF[i]);
      if (i == 0) chk("R11 empty at base", stk_empty, 1);
      if (i == 8) chk("R11 full at limit", stk_full, 1);
    end

    // R7 sticky, then cleared
    @(negedge clk);
    chk("R7 flags held", {ovf_err, unf_err}, 2'b11);
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk("R7 flags cleared", {ovf_err, unf_err}, 2'b00);

    // R9 back-pressure
    step(1, 0, 16'h5A5A, 0, 0);
    out_ready = 0;
    step(1, 1, 0, 0, 0);
    chk("R9 popped valid", out_valid, 1);
    chk("R9 popped data", out_data, 16'h5A5A);
    chk("R9 ready low", req_ready, 0);
    step(1, 0, 16'h1234, 0, 0);
    chk("R9 data held", out_data, 16'h5A5A);
    chk("R9 push held off", sp_out, 8'h20);
    out_ready = 1; @(negedge clk);
    chk("R9 drained", out_valid, 0);

    // R8 load beats request
    req_valid = 1; req_pop = 0; req_data = 16'h9999; sp_load = 1; sp_load_val = 8'h1E;
    #1 chk("R8 ready low on load", req_ready, 0);
    @(negedge clk); req_valid = 0; sp_load = 0;
    chk("R8 load value", sp_out, 8'h1E);

    // R10 odd pointer: push from 1D writes word index 0D
    step(0, 0, 0, 1, 8'h1D);
    step(1, 0, 16'hBEEF, 0, 0);
    chk("R10 sp after odd push", sp_out, 8'h1B);
    step(0, 0, 0, 1, 8'h1A);
    step(1, 1, 0, 0, 0);
    chk("R10 word index", out_data, 16'hBEEF);
    chk("R10 sp after pop", sp_out, 8'h1C);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule